// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Interrupt Detection

This block is one bank of a general-purpose I/O controller. It holds sixteen pins behind a small 32-bit register port. Each pin can be an input or an output. A per-pin access mask gates which pins the data register may touch. A per-pin input enable either passes the synchronised pad value or forces it low.

Every pin has its own interrupt detector. It can sense a rising edge, a falling edge, either edge, a high level or a low level. Edge events are latched in a raw status register and cleared by writing ones to an acknowledge register. Level events follow the pin and are not latched. A per-pin enable forms the masked status, and a single interrupt line is raised while any masked bit is set.

Software writes a register in one request cycle. A read returns its data on `rdata_o` one clock after the request cycle.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin n uses bit n of every register. Register bits 31:16 always read as zero. A read returns its value on `rdata_o` one clock after the request. The register map is: data 0x00, access mask 0x04, direction 0x08, sense select 0x0C, both-edge 0x10, polarity 0x14, interrupt enable 0x18, raw status 0x1C, masked status 0x20, acknowledge 0x24, input enable 0x28.
- R2: A write to the data register changes only the output bits whose access-mask bit is 1. Reads of data return 0 for masked bits. For an unmasked pin, a read returns the output value when the direction bit is 1 and the synchronised input sample when it is 0.
- R3: A direction bit of 1 drives `pin_oe_o` high for that pin, and `pin_o` carries the stored output value. A direction bit of 0 drives `pin_oe_o` low. After reset every pin is an input.
- R4: With sense select 0, both-edge 0 and polarity 1, a 0-to-1 change on the sample sets the latched raw status bit. A 1-to-0 change does not.
- R5: With sense select 0, both-edge 0 and polarity 0, a 1-to-0 change sets the latched raw status bit. A 0-to-1 change does not.
- R6: With sense select 0 and both-edge 1, changes in either direction set the raw status bit, whatever the polarity bit holds.
- R7: With sense select 1, the raw status bit equals 1 while the sample matches the polarity bit (1 = high, 0 = low) and is not latched. A write of 1 to the acknowledge register leaves it set while the level persists.
- R8: Writing 1 to an acknowledge bit clears that latched edge status bit. Writing 0 leaves it unchanged. The acknowledge register reads as zero.
- R9: Masked status equals raw status AND interrupt enable. `irq_o` is 1 exactly when any masked status bit is 1.
- R10: With its input-enable bit at 0, a pin's sample is held low. It reads as 0 in the data register and cannot set edge status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one clock after a read request |
| pin_i | input | 16 | Pad input values |
| pin_o | output | 16 | Pad output values |
| pin_oe_o | output | 16 | Pad output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
A pin change passes two synchroniser flops before it reaches the sample. A level-mode status bit follows two clocks after the pin changes. A latched edge bit, and `irq_o` with it, follows one clock later, three clocks after the change. Register writes take effect at the clock that ends the request, and read data appears one clock after the read request. The bench therefore waits five clocks after every pin change before it reads status back. It samples `rdata_o`, `pin_o`, `pin_oe_o` and `irq_o` on the falling edge after the clock that updates them.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam logic [7:0] OFS_DATA  = 8'h00;
  localparam logic [7:0] OFS_AMSK  = 8'h04;
  localparam logic [7:0] OFS_DIR   = 8'h08;
  localparam logic [7:0] OFS_SENSE = 8'h0C;
  localparam logic [7:0] OFS_BOTH  = 8'h10;
  localparam logic [7:0] OFS_POL   = 8'h14;
  localparam logic [7:0] OFS_IEN   = 8'h18;
  localparam logic [7:0] OFS_RAW   = 8'h1C;
  localparam logic [7:0] OFS_MSTAT = 8'h20;
  localparam logic [7:0] OFS_ACK   = 8'h24;
  localparam logic [7:0] OFS_INEN  = 8'h28;
endpackage

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic inen_i,
  input  logic sense_i,
  input  logic both_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic samp_o,
  output logic raw_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, edge_q, rise, fall, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign samp_o = sync_q[SYNC_STAGES-1] & inen_i;
  assign rise   = samp_o & ~prev_q;
  assign fall   = ~samp_o & prev_q;
  // disabled input never sets status, including the drop it causes
  assign hit    = inen_i & ~sense_i & (both_i ? (rise | fall) : (pol_i ? rise : fall));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      prev_q <= samp_o;
      if (hit)        edge_q <= 1'b1;
      else if (clr_i) edge_q <= 1'b0;
    end
  end

  assign raw_o = sense_i ? ~(samp_o ^ pol_i) : edge_q;

  AST_EDGE_NEEDS_INEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(edge_q) |-> ($past(inen_i) && !$past(sense_i))); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !inen_i) |=> !edge_q); // R8
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_PINS = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [N_PINS-1:0] samp_i,
  input  logic [N_PINS-1:0] raw_i,
  output logic [N_PINS-1:0] out_o,
  output logic [N_PINS-1:0] dir_o,
  output logic [N_PINS-1:0] sense_o,
  output logic [N_PINS-1:0] both_o,
  output logic [N_PINS-1:0] pol_o,
  output logic [N_PINS-1:0] ien_o,
  output logic [N_PINS-1:0] inen_o,
  output logic [N_PINS-1:0] clr_o
);
  logic [N_PINS-1:0] out_q, amsk_q, dir_q, sense_q, both_q, pol_q, ien_q, inen_q;
  logic [N_PINS-1:0] wv, rd_val;
  logic [DW-1:0]     rd_d;
  logic              wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;
  assign wv = wdata_i[N_PINS-1:0];

  function automatic logic hit_ofs(input logic [AW-1:0] a, input logic [7:0] o);
    return a == AW'(o);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0; amsk_q <= '0; dir_q <= '0; sense_q <= '0;
      both_q <= '0; pol_q <= '0; ien_q <= '0; inen_q <= '0;
    end else if (wr) begin
      if (hit_ofs(addr_i, OFS_DATA))  out_q   <= (out_q & ~amsk_q) | (wv & amsk_q);
      if (hit_ofs(addr_i, OFS_AMSK))  amsk_q  <= wv;
      if (hit_ofs(addr_i, OFS_DIR))   dir_q   <= wv;
      if (hit_ofs(addr_i, OFS_SENSE)) sense_q <= wv;
      if (hit_ofs(addr_i, OFS_BOTH))  both_q  <= wv;
      if (hit_ofs(addr_i, OFS_POL))   pol_q   <= wv;
      if (hit_ofs(addr_i, OFS_IEN))   ien_q   <= wv;
      if (hit_ofs(addr_i, OFS_INEN))  inen_q  <= wv;
    end
  end

  assign clr_o = (wr && hit_ofs(addr_i, OFS_ACK)) ? wv : '0;

  always_comb begin
    rd_val = '0;
    if      (hit_ofs(addr_i, OFS_DATA))  rd_val = amsk_q & ((dir_q & out_q) | (~dir_q & samp_i));
    else if (hit_ofs(addr_i, OFS_AMSK))  rd_val = amsk_q;
    else if (hit_ofs(addr_i, OFS_DIR))   rd_val = dir_q;
    else if (hit_ofs(addr_i, OFS_SENSE)) rd_val = sense_q;
    else if (hit_ofs(addr_i, OFS_BOTH))  rd_val = both_q;
    else if (hit_ofs(addr_i, OFS_POL))   rd_val = pol_q;
    else if (hit_ofs(addr_i, OFS_IEN))   rd_val = ien_q;
    else if (hit_ofs(addr_i, OFS_RAW))   rd_val = raw_i;
    else if (hit_ofs(addr_i, OFS_MSTAT)) rd_val = raw_i & ien_q;
    else if (hit_ofs(addr_i, OFS_INEN))  rd_val = inen_q;
    rd_d = '0;
    rd_d[N_PINS-1:0] = rd_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd) rdata_o <= rd_d;
  end

  assign out_o   = out_q;
  assign dir_o   = dir_q;
  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign pol_o   = pol_q;
  assign ien_o   = ien_q;
  assign inen_o  = inen_q;

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:N_PINS] == '0); // R1
  AST_MASKED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit_ofs(addr_i, OFS_DATA)) |=> ((out_q ^ $past(out_q)) & ~$past(amsk_q)) == '0); // R2
  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit_ofs(addr_i, OFS_DIR)) |=> dir_o == $past(wv)); // R3
  AST_ACK_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit_ofs(addr_i, OFS_ACK)) |=> rdata_o == '0); // R8
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int unsigned N_PINS      = 16,
  parameter int unsigned DW          = 32,
  parameter int unsigned AW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] samp, raw, out_v, dir_v, sense_v, both_v, pol_v, ien_v, inen_v, clr_v;

  gpio_bank_regs #(.N_PINS(N_PINS), .DW(DW), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .samp_i(samp), .raw_i(raw), .out_o(out_v), .dir_o(dir_v),
    .sense_o(sense_v), .both_o(both_v), .pol_o(pol_v), .ien_o(ien_v),
    .inen_o(inen_v), .clr_o(clr_v)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    gpio_pin_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk_i, .rst_ni, .pin_i(pin_i[g]), .inen_i(inen_v[g]),
      .sense_i(sense_v[g]), .both_i(both_v[g]), .pol_i(pol_v[g]),
      .clr_i(clr_v[g]), .samp_o(samp[g]), .raw_o(raw[g])
    );
  end

  assign pin_o    = out_v;
  assign pin_oe_o = dir_v;
  assign irq_o    = |(raw & ien_v);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_v == '0) |-> !irq_o); // R9
  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw == '0) |-> !irq_o); // R9
endmodule

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
  import gpio_bank_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:0] pin_in = '0, pin_out, pin_oe;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank_ctrl u_gpio_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // {sense, both, pol, start level, end level, expected raw bit}
  localparam logic [5:0] VEC [9] = '{
    6'b001011, 6'b001100, 6'b000101, 6'b000010,
    6'b010011, 6'b011101, 6'b101011, 6'b101100, 6'b100001
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3); rst_n = 1'b1; idle(2);
    chk("R3 reset oe", {16'h0, pin_oe}, 32'h0);
    chk("R9 reset irq", {31'h0, irq}, 32'h0);
    rd(OFS_DIR, v); chk("R1 reset dir", v, 32'h0);
    rd(OFS_RAW, v); chk("R1 reset raw", v, 32'h0);

    wr(OFS_DIR, 32'hFFFF_FFFF);
    rd(OFS_DIR, v); chk("R1 upper zero", v, 32'h0000_FFFF);
    chk("R3 oe all out", {16'h0, pin_oe}, 32'h0000_FFFF);
    wr(OFS_AMSK, 32'hFFFF);
    wr(OFS_DATA, 32'hA5A5);
    chk("R3 pin drive", {16'h0, pin_out}, 32'h0000_A5A5);
    wr(OFS_AMSK, 32'h00FF);
    wr(OFS_DATA, 32'h5A5A);
    chk("R2 masked write", {16'h0, pin_out}, 32'h0000_A55A);
    rd(OFS_DATA, v); chk("R2 masked read", v, 32'h0000_005A);

    wr(OFS_DIR, 32'h0);
    chk("R3 oe inputs", {16'h0, pin_oe}, 32'h0);
    wr(OFS_AMSK, 32'hFFFF);
    wr(OFS_INEN, 32'h000F);
    pin_in = 16'h00FF; idle(4);
    rd(OFS_DATA, v); chk("R10 input gated", v, 32'h0000_000F);

    pin_in = 16'h0; idle(5);
    wr(OFS_ACK, 32'hFFFF);
    foreach (VEC[i]) begin
      string tag;
      tag = VEC[i][5] ? "R7 level" : VEC[i][4] ? "R6 both" : VEC[i][3] ? "R4 rise" : "R5 fall";
      wr(OFS_SENSE, {31'h0, VEC[i][5]});
      wr(OFS_BOTH,  {31'h0, VEC[i][4]});
      wr(OFS_POL,   {31'h0, VEC[i][3]});
      pin_in[0] = VEC[i][2]; idle(5);
      wr(OFS_ACK, 32'h1);
      pin_in[0] = VEC[i][1]; idle(5);
      rd(OFS_RAW, v); chk(tag, {31'h0, v[0]}, {31'h0, VEC[i][0]});
    end

    wr(OFS_SENSE, 32'h0); wr(OFS_BOTH, 32'h0); wr(OFS_POL, 32'h1);
    pin_in[0] = 1'b0; idle(5);
    wr(OFS_ACK, 32'hFFFF);
    wr(OFS_IEN, 32'h0);
    pin_in[0] = 1'b1; idle(5);
    chk("R9 irq disabled", {31'h0, irq}, 32'h0);
    rd(OFS_MSTAT, v); chk("R9 mstat disabled", v, 32'h0);
    rd(OFS_RAW, v); chk("R4 raw latched", v, 32'h1);
    wr(OFS_IEN, 32'h1);
    chk("R9 irq enabled", {31'h0, irq}, 32'h1);
    rd(OFS_MSTAT, v); chk("R9 mstat enabled", v, 32'h1);
    wr(OFS_ACK, 32'h0);
    rd(OFS_RAW, v); chk("R8 zero ack keeps", v, 32'h1);
    rd(OFS_ACK, v); chk("R8 ack reads zero", v, 32'h0);
    wr(OFS_ACK, 32'h1);
    rd(OFS_RAW, v); chk("R8 ack clears", v, 32'h0);
    chk("R8 irq cleared", {31'h0, irq}, 32'h0);

    wr(OFS_SENSE, 32'h1); idle(3);
    wr(OFS_ACK, 32'h1);
    rd(OFS_RAW, v); chk("R7 ack on active level", v, 32'h1);
    pin_in[0] = 1'b0; idle(4);
    rd(OFS_RAW, v); chk("R7 level not latched", v, 32'h0);

    wr(OFS_SENSE, 32'h0);
    wr(OFS_INEN, 32'h0001);
    wr(OFS_BOTH, 32'h0002);
    pin_in[1] = 1'b1; idle(5);
    pin_in[1] = 1'b0; idle(5);
    rd(OFS_RAW, v); chk("R10 disabled no edge", v, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule